// File: doc/BRIEF.md
# Cycle-by-Cycle Current Limiter

This block cuts gate drive for the remainder of a PWM period whenever the phase-current comparator reports an overcurrent. It then decides when drive may return, based on a 4-bit policy code. It sits between the PWM generator and the gate-driver logic.

While limiting is active, the block raises a recirculation request. Downstream gate logic uses this request in place of the normal PWM commands. Depending on the code, the same event also pulls an active-low fault pin.

The block supports three recovery policies:
- resume at the next period start;
- resume once the synchronised comparator falls back below the limit;
- resume after a programmed number of period starts.

In addition, one code makes the block observe without acting, and the remaining codes disable it. The comparator bit is asynchronous to the clock and is brought in through a flop synchroniser.

Top module: `cbc_limiter`

## Requirements
- R1: With policy code 0 or 1, a detected overcurrent holds `recirc_req` high until the first `pwm_start` pulse sampled while the synchronised comparator is low; that pulse clears it on the same clock edge. A pulse seen while overcurrent persists leaves it high.
- R2: With code 2 or 3 and `hs_mod`=1, `recirc_req` clears on the first clock edge at which the synchronised comparator is low, without waiting for `pwm_start`.
- R3: With code 4 or 5 and `retry_cyc`=N (1..7), `recirc_req` stays high through the first N-1 `pwm_start` pulses after the overcurrent ends and clears on the Nth.
- R4: Codes 0, 2 and 4 drive `fault_n` low exactly while limiting. Codes 1, 3 and 5 keep `fault_n` high.
- R5: For codes 0 to 5, `oc_status` is high exactly while `recirc_req` is high.
- R6: Codes 2 or 3 with `hs_mod`=0 recover as in R1, on the next `pwm_start`.
- R7: Code 6 never raises `recirc_req` and never lowers `fault_n`. In this mode `oc_status` follows the synchronised comparator with one register of delay.
- R8: Codes 7 to 15 keep all three outputs inactive (`recirc_req`=0, `fault_n`=1, `oc_status`=0) regardless of the comparator. Switching to such a code while limiting clears `recirc_req` on the next clock edge.
- R9: With code 4 or 5, `retry_cyc`=0 recovers as in R1.
- R10: `oc_raw` passes through a two-flop synchroniser. `recirc_req` therefore rises on the third rising clock edge after `oc_raw` goes high.
- R11: After reset: `recirc_req`=0, `fault_n`=1, `oc_status`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_start | input | 1 | One-clock pulse at each PWM period start |
| oc_raw | input | 1 | Asynchronous overcurrent comparator output |
| hs_mod | input | 1 | High when high-side modulation is in use |
| mode | input | 4 | Limiter policy code |
| retry_cyc | input | 3 | Period count for counted recovery |
| recirc_req | output | 1 | Request to force the power stage into recirculation |
| fault_n | output | 1 | Active-low fault indication |
| oc_status | output | 1 | Limiting or reported overcurrent |

## Verification
The bench holds the comparator high across a period-start pulse. A design that let the pulse win over a persistent overcurrent would release drive into the fault.

It counts period starts under the counted policy, one pulse at a time. An off-by-one in the counter would release drive a period early or late.

It exercises the threshold codes without high-side modulation. A design missing the fallback would release drive as soon as the current dipped.

It also covers the zero retry count, a policy change in the middle of limiting, and the exact synchroniser latency. A wrong stage count shifts the rising edge of `recirc_req`.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
   typedef enum logic [2:0] {
      POL_NEXT   = 3'd0,
      POL_THRESH = 3'd1,
      POL_NCYC   = 3'd2,
      POL_REPORT = 3'd3,
      POL_OFF    = 3'd4
   } cbc_pol_e;
endpackage

// File: rtl/cbc_sync.sv
module cbc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   initial begin
      if (STAGES < 2) $error("cbc_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain_q[0] <= 1'b0;
               else        chain_q[0] <= d_i;
         end else begin : g_rest
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain_q[g] <= 1'b0;
               else        chain_q[g] <= chain_q[g-1];
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cbc_decode.sv
module cbc_decode
   import cbc_pkg::*;
#(
   parameter int MODE_W = 4,
   parameter int CNT_W  = 3
) (
   input  logic [MODE_W-1:0] mode_i,
   input  logic              hs_mod_i,
   input  logic [CNT_W-1:0]  retry_i,
   output cbc_pol_e          pol_o,
   output logic              fault_en_o
);
   initial begin
      if (MODE_W < 3) $error("cbc_decode: MODE_W must hold codes up to 6");
   end

   localparam logic [MODE_W-1:0] CODE_REPORT = MODE_W'(6);

   always_comb begin
      pol_o      = POL_OFF;
      fault_en_o = 1'b0;
      if (mode_i < CODE_REPORT) begin
         fault_en_o = ~mode_i[0];
         unique case (mode_i[2:1])
            2'd0:    pol_o = POL_NEXT;
            2'd1:    pol_o = hs_mod_i ? POL_THRESH : POL_NEXT;
            default: pol_o = (retry_i == '0) ? POL_NEXT : POL_NCYC;
         endcase
      end else if (mode_i == CODE_REPORT) begin
         pol_o = POL_REPORT;
      end
   end
endmodule

// File: rtl/cbc_ctrl.sv
module cbc_ctrl
   import cbc_pkg::*;
#(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwm_start_i,
   input  logic             oc_i,
   input  cbc_pol_e         pol_i,
   input  logic             fault_en_i,
   input  logic [CNT_W-1:0] retry_i,
   output logic             recirc_o,
   output logic             fault_o,
   output logic             status_o
);
   initial begin
      if (CNT_W < 1) $error("cbc_ctrl: CNT_W must be positive");
   end

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic             lim_q, lim_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             fault_q, status_q;
   logic             acting, trip;

   always_comb begin
      acting = (pol_i == POL_NEXT) || (pol_i == POL_THRESH) || (pol_i == POL_NCYC);
      trip   = acting && oc_i;
      lim_d  = lim_q;
      cnt_d  = cnt_q;
      if (trip) begin
         lim_d = 1'b1;
         cnt_d = retry_i;
      end else begin
         unique case (pol_i)
            POL_NEXT:   if (pwm_start_i) lim_d = 1'b0;
            POL_THRESH: lim_d = 1'b0;
            POL_NCYC:
               if (pwm_start_i && lim_q) begin
                  if (cnt_q <= ONE) lim_d = 1'b0;
                  else              cnt_d = cnt_q - ONE;
               end
            default:    lim_d = 1'b0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lim_q    <= 1'b0;
         cnt_q    <= '0;
         fault_q  <= 1'b0;
         status_q <= 1'b0;
      end else begin
         lim_q    <= lim_d;
         cnt_q    <= cnt_d;
         fault_q  <= lim_d && fault_en_i;
         status_q <= lim_d || ((pol_i == POL_REPORT) && oc_i);
      end
   end

   assign recirc_o = lim_q;
   assign fault_o  = fault_q;
   assign status_o = status_q;

   // R1
   next_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pol_i == POL_NEXT && pwm_start_i && !oc_i) |=> !lim_q);

   // R2
   thresh_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pol_i == POL_THRESH && !oc_i) |=> !lim_q);

   // R3
   ncyc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pol_i == POL_NCYC && lim_q && !oc_i && pwm_start_i && cnt_q > ONE) |=> lim_q);

   // R5
   trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acting && oc_i) |=> (lim_q && status_q));

   // R7
   report_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pol_i == POL_REPORT) |=> (!lim_q && !fault_q));

   // R8
   off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pol_i == POL_OFF) |=> (!lim_q && !fault_q && !status_q));
endmodule

// File: rtl/cbc_limiter.sv
module cbc_limiter
   import cbc_pkg::*;
#(
   parameter int MODE_W      = 4,
   parameter int CNT_W       = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwm_start,
   input  logic              oc_raw,
   input  logic              hs_mod,
   input  logic [MODE_W-1:0] mode,
   input  logic [CNT_W-1:0]  retry_cyc,
   output logic              recirc_req,
   output logic              fault_n,
   output logic              oc_status
);
   logic     oc_sync;
   cbc_pol_e pol;
   logic     fault_en;
   logic     fault_hi;

   cbc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (oc_raw),
      .q_o   (oc_sync)
   );

   cbc_decode #(.MODE_W(MODE_W), .CNT_W(CNT_W)) u_dec (
      .mode_i     (mode),
      .hs_mod_i   (hs_mod),
      .retry_i    (retry_cyc),
      .pol_o      (pol),
      .fault_en_o (fault_en)
   );

   cbc_ctrl #(.CNT_W(CNT_W)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .pwm_start_i (pwm_start),
      .oc_i        (oc_sync),
      .pol_i       (pol),
      .fault_en_i  (fault_en),
      .retry_i     (retry_cyc),
      .recirc_o    (recirc_req),
      .fault_o     (fault_hi),
      .status_o    (oc_status)
   );

   assign fault_n = ~fault_hi;

   // R4
   fault_needs_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fault_n |-> recirc_req);
endmodule

// File: tb/cbc_limiter_test.sv
module cbc_limiter_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pwm_start = 1'b0;
   logic       oc_raw = 1'b0;
   logic       hs_mod = 1'b0;
   logic [3:0] mode = 4'd0;
   logic [2:0] retry_cyc = 3'd0;
   logic       recirc_req, fault_n, oc_status;
   int         checks = 0;
   int         failures = 0;

   always #10 clk = ~clk;

   cbc_limiter uut (
      .clk(clk), .rst_n(rst_n), .pwm_start(pwm_start), .oc_raw(oc_raw),
      .hs_mod(hs_mod), .mode(mode), .retry_cyc(retry_cyc),
      .recirc_req(recirc_req), .fault_n(fault_n), .oc_status(oc_status)
   );

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse();
      pwm_start = 1'b1;
      step(1);
      pwm_start = 1'b0;
   endtask

   // expected order: {recirc_req, fault_n, oc_status}
   task automatic chk(input string req, input logic [2:0] exp);
      logic [2:0] act;
      act = {recirc_req, fault_n, oc_status};
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic settle();
      oc_raw = 1'b0;
      step(3);
      pulse();
      pulse();
   endtask

   task automatic t_reset();
      chk("R11", 3'b010);
   endtask

   task automatic t_next_fault();
      settle(); mode = 4'd0;
      oc_raw = 1'b1; step(2);
      chk("R10", 3'b010);
      step(1);
      chk("R10", 3'b101);
      pulse();
      chk("R1", 3'b101);
      oc_raw = 1'b0; step(3);
      chk("R1", 3'b101);
      pulse();
      chk("R1", 3'b010);
   endtask

   task automatic t_next_silent();
      settle(); mode = 4'd1;
      oc_raw = 1'b1; step(3);
      chk("R4", 3'b111);
      oc_raw = 1'b0; step(3);
      pulse();
      chk("R1", 3'b010);
   endtask

   task automatic t_thresh();
      settle(); mode = 4'd2; hs_mod = 1'b1;
      oc_raw = 1'b1; step(3);
      chk("R2", 3'b101);
      oc_raw = 1'b0; step(2);
      chk("R2", 3'b101);
      step(1);
      chk("R2", 3'b010);
      hs_mod = 1'b0;
   endtask

   task automatic t_thresh_fallback();
      settle(); mode = 4'd3; hs_mod = 1'b0;
      oc_raw = 1'b1; step(3);
      oc_raw = 1'b0; step(4);
      chk("R6", 3'b111);
      pulse();
      chk("R6", 3'b010);
   endtask

   task automatic t_count();
      settle(); mode = 4'd4; retry_cyc = 3'd3;
      oc_raw = 1'b1; step(3);
      oc_raw = 1'b0; step(3);
      pulse(); chk("R3", 3'b101);
      pulse(); chk("R3", 3'b101);
      pulse(); chk("R3", 3'b010);
   endtask

   task automatic t_count_zero();
      settle(); mode = 4'd5; retry_cyc = 3'd0;
      oc_raw = 1'b1; step(3);
      chk("R4", 3'b111);
      oc_raw = 1'b0; step(3);
      pulse(); chk("R9", 3'b010);
   endtask

   task automatic t_report();
      settle(); mode = 4'd6;
      oc_raw = 1'b1; step(3);
      chk("R7", 3'b011);
      oc_raw = 1'b0; step(3);
      chk("R7", 3'b010);
   endtask

   task automatic t_disabled();
      settle(); mode = 4'd9;
      oc_raw = 1'b1; step(4);
      chk("R8", 3'b010);
      mode = 4'd15; step(2);
      chk("R8", 3'b010);
      oc_raw = 1'b0;
      settle(); mode = 4'd0;
      oc_raw = 1'b1; step(3);
      oc_raw = 1'b0; step(3);
      chk("R5", 3'b101);
      mode = 4'd7; step(1);
      chk("R8", 3'b010);
   endtask

   initial begin
      step(2);
      t_reset();
      rst_n = 1'b1;
      step(1);
      t_next_fault();
      t_next_silent();
      t_thresh();
      t_thresh_fallback();
      t_count();
      t_count_zero();
      t_report();
      t_disabled();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule